// File: doc/BRIEF.md
# Multi-channel limit fault voter

This block watches 32 sensor channels in parallel. Every clock cycle it compares each channel's 12-bit unsigned sample with that channel's own low and high limits. It registers the result as a fault word that holds one bit per channel. When two or more channels are out of limit together, the block latches a shutdown output. A single faulty channel never causes a shutdown.

An optional dwell qualifier can require the multi-fault condition to persist for a programmed number of cycles before the trip. A small read port lets a host fetch either the fault word or a flag that shows more than one fault. With a dwell of zero, the path from a sample change to shutdown is two clock edges, which is tens of nanoseconds at normal clock rates.

Top module: `limit_fault_voter`

## Requirements
- R1: Channel i is out of limit when its sample is strictly greater than its high limit or strictly less than its low limit. A sample equal to either limit is in range. Bit i of `fault_word` shows the result of the samples presented before the most recent clock edge.
- R2: `multi_fault` is 1 exactly when two or more bits of `fault_word` are set. It is 0 when zero bits or one bit is set.
- R3: A single out-of-limit channel never asserts `shutdown`, however long it persists.
- R4: When `dwell_cycles` is 0, `shutdown` rises at the second clock edge after two out-of-limit samples are presented.
- R5: When `dwell_cycles` is P, `shutdown` rises at edge 2+P if the multi-fault condition holds without a break. If `multi_fault` drops before then, the dwell count restarts from zero. The dwell counter is 16 bits wide and saturates.
- R6: Once set, `shutdown` stays high until the clock edge at which `shut_clr` is sampled high, even after the faults go away.
- R7: When a trip condition and `shut_clr` fall on the same edge, the trip wins and `shutdown` stays high.
- R8: The synchronous active-high reset `rst` clears `fault_word`, the dwell counter and `shutdown`.
- R9: `rd_data` is combinational. With `rd_addr`=0 it equals `fault_word`. With `rd_addr`=1 it is `multi_fault` in bit 0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samples | input | 384 | Channel samples; channel i occupies bits [12i+11:12i] |
| lo_limits | input | 384 | Per-channel low limits, same packing |
| hi_limits | input | 384 | Per-channel high limits, same packing |
| dwell_cycles | input | 16 | Extra cycles the multi-fault condition must persist |
| shut_clr | input | 1 | Releases the shutdown latch |
| rd_addr | input | 1 | Host read select: 0 fault word, 1 multi-fault flag |
| rd_data | output | 32 | Host read data |
| fault_word | output | 32 | Registered per-channel fault bits |
| multi_fault | output | 1 | Two or more fault bits set |
| shutdown | output | 1 | Latched shutdown request |

## Verification
A new trip and a release of the latch can fall on the same edge. This is provoked by pulsing `shut_clr` in the cycle in which a registered fault word with two bits set first makes the trip condition true. The trip must win, so `shutdown` is expected to stay high at that edge. It is expected to fall only at a later clear that is issued after the fault word is empty. A reset applied while the latch is set and faults are still present is also judged: on the next read the fault word must be zero and `shutdown` must be low.

// File: rtl/limit_fault_voter.sv
module limit_fault_voter #(
  parameter int NCH = 32,
  parameter int SW  = 12,
  parameter int PW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*SW-1:0] samples,
  input  logic [NCH*SW-1:0] lo_limits,
  input  logic [NCH*SW-1:0] hi_limits,
  input  logic [PW-1:0]     dwell_cycles,
  input  logic              shut_clr,
  input  logic              rd_addr,
  output logic [NCH-1:0]    rd_data,
  output logic [NCH-1:0]    fault_word,
  output logic              multi_fault,
  output logic              shutdown
);

  localparam logic [NCH-1:0] WORD_ONE = {{(NCH-1){1'b0}}, 1'b1};
  localparam logic [PW-1:0]  DWELL_ONE = {{(PW-1){1'b0}}, 1'b1};

  logic [NCH-1:0] out_now;
  logic [PW-1:0]  dwell;
  logic           trip;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    logic [SW-1:0] s, lo, hi;
    assign s  = samples[i*SW +: SW];
    assign lo = lo_limits[i*SW +: SW];
    assign hi = hi_limits[i*SW +: SW];
    assign out_now[i] = (s > hi) || (s < lo);
  end

  always_ff @(posedge clk) begin
    if (rst) fault_word <= '0;
    else     fault_word <= out_now;
  end

  // clearing the lowest set bit leaves something only if two or more were set
  assign multi_fault = |(fault_word & (fault_word - WORD_ONE));

  always_ff @(posedge clk) begin
    if (rst || !multi_fault) dwell <= '0;
    else if (dwell != '1)    dwell <= dwell + DWELL_ONE;
  end

  assign trip = multi_fault && (dwell >= dwell_cycles);

  always_ff @(posedge clk) begin
    if (rst)           shutdown <= 1'b0;
    else if (trip)     shutdown <= 1'b1;
    else if (shut_clr) shutdown <= 1'b0;
  end

  assign rd_data = rd_addr ? {{(NCH-1){1'b0}}, multi_fault} : fault_word;

endmodule

// File: rtl/limit_fault_voter_chk.sv
module limit_fault_voter_chk #(
  parameter int NCH = 32,
  parameter int PW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [PW-1:0]  dwell_cycles,
  input logic           shut_clr,
  input logic           rd_addr,
  input logic [NCH-1:0] rd_data,
  input logic [NCH-1:0] fault_word,
  input logic           multi_fault,
  input logic           shutdown
);

  p_multi_r2: assert property (@(posedge clk) disable iff (rst)
    multi_fault == ($countones(fault_word) >= 2));

  p_no_single_trip_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown) |-> $past(multi_fault));

  p_fast_trip_r4: assert property (@(posedge clk) disable iff (rst)
    (multi_fault && dwell_cycles == '0) |=> shutdown);

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (shutdown && !shut_clr) |=> shutdown);

  p_trip_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (multi_fault && dwell_cycles == '0 && shut_clr) |=> shutdown);

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (fault_word == '0 && !shutdown));

  p_read_mux_r9: assert property (@(posedge clk) disable iff (rst)
    rd_data == (rd_addr ? {{(NCH-1){1'b0}}, multi_fault} : fault_word));

endmodule

bind limit_fault_voter limit_fault_voter_chk #(.NCH(NCH), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .dwell_cycles(dwell_cycles), .shut_clr(shut_clr),
  .rd_addr(rd_addr), .rd_data(rd_data), .fault_word(fault_word),
  .multi_fault(multi_fault), .shutdown(shutdown)
);

// File: tb/tb_limit_fault_voter.sv
module tb_limit_fault_voter;
  localparam int NCH = 32;
  localparam int SW  = 12;
  localparam int PW  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic [NCH*SW-1:0] samples, lo_limits, hi_limits;
  logic [PW-1:0]     dwell_cycles = '0;
  logic              shut_clr = 1'b0;
  logic              rd_addr = 1'b0;
  logic [NCH-1:0]    rd_data, fault_word;
  logic              multi_fault, shutdown;

  logic [SW-1:0] smp [NCH];
  logic [SW-1:0] lo  [NCH];
  logic [SW-1:0] hi  [NCH];

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      samples[i*SW +: SW]   = smp[i];
      lo_limits[i*SW +: SW] = lo[i];
      hi_limits[i*SW +: SW] = hi[i];
    end
  end

  limit_fault_voter #(.NCH(NCH), .SW(SW), .PW(PW)) dut (
    .clk(clk), .rst(rst), .samples(samples), .lo_limits(lo_limits),
    .hi_limits(hi_limits), .dwell_cycles(dwell_cycles), .shut_clr(shut_clr),
    .rd_addr(rd_addr), .rd_data(rd_data), .fault_word(fault_word),
    .multi_fault(multi_fault), .shutdown(shutdown)
  );

  typedef struct {
    logic [NCH-1:0] word;
    bit             shut;
    string          tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  task automatic tick(input logic [NCH-1:0] w, input bit sh, input string tag);
    exp_t e;
    e.word = w; e.shut = sh; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic all_ok();
    for (int i = 0; i < NCH; i++) smp[i] = 12'd150;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        logic [NCH-1:0] er;
        bit em;
        e  = q.pop_front();
        em = ($countones(e.word) >= 2);
        er = rd_addr ? {{(NCH-1){1'b0}}, em} : e.word;
        checks++;
        if (fault_word !== e.word) begin
          fails++;
          $display("FAIL %s fault_word=%h expected %h", e.tag, fault_word, e.word);
        end
        checks++;
        if (shutdown !== e.shut) begin
          fails++;
          $display("FAIL %s shutdown=%b expected %b", e.tag, shutdown, e.shut);
        end
        checks++;
        if (rd_data !== er) begin
          fails++;
          $display("FAIL %s R9 R2 rd_data=%h expected %h (rd_addr=%b)", e.tag, rd_data, er, rd_addr);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [NCH-1:0] B0 = 32'h1;

  initial begin
    for (int i = 0; i < NCH; i++) begin lo[i] = 12'd100; hi[i] = 12'd200; end
    all_ok();
    @(negedge clk);
    rst = 1'b1;
    tick('0, 0, "R8 reset");
    tick('0, 0, "R8 reset");
    rst = 1'b0;
    tick('0, 0, "R1 all in range");
    smp[3] = 12'd200; smp[4] = 12'd100;
    tick('0, 0, "R1 equal to limit is in range");
    smp[3] = 12'd201;
    tick(B0 << 3, 0, "R1 above high");
    rd_addr = 1'b1;
    tick(B0 << 3, 0, "R3 single fault");
    tick(B0 << 3, 0, "R3 single fault held");
    smp[3] = 12'd150; smp[5] = 12'd99;
    tick(B0 << 5, 0, "R1 below low");
    tick(B0 << 5, 0, "R3 single fault held");
    smp[5] = 12'd150; rd_addr = 1'b0;
    tick('0, 0, "R1 recovered");
    smp[0] = 12'd4095; smp[31] = 12'd0;
    tick((B0 << 31) | B0, 0, "R2 R4 first edge");
    rd_addr = 1'b1;
    tick((B0 << 31) | B0, 1, "R4 second edge");
    all_ok();
    tick('0, 1, "R6 latched after faults clear");
    rd_addr = 1'b0;
    tick('0, 1, "R6 latched");
    shut_clr = 1'b1;
    tick('0, 0, "R6 clear");
    shut_clr = 1'b0;
    tick('0, 0, "R6 stays clear");
    smp[1] = 12'd300; smp[2] = 12'd50;
    tick(32'h6, 0, "R7 faults registered");
    shut_clr = 1'b1;
    tick(32'h6, 1, "R7 trip wins over clear");
    shut_clr = 1'b0;
    all_ok();
    tick('0, 1, "R7 latched");
    shut_clr = 1'b1;
    tick('0, 0, "R7 later clear");
    shut_clr = 1'b0;
    dwell_cycles = 16'd3;
    smp[6] = 12'd201; smp[7] = 12'd201;
    tick(32'hC0, 0, "R5 edge1");
    tick(32'hC0, 0, "R5 edge2");
    tick(32'hC0, 0, "R5 edge3");
    tick(32'hC0, 0, "R5 edge4");
    tick(32'hC0, 1, "R5 edge5 trip");
    all_ok();
    tick('0, 1, "R5 latched");
    shut_clr = 1'b1;
    tick('0, 0, "R5 clear");
    shut_clr = 1'b0;
    smp[6] = 12'd201; smp[7] = 12'd201;
    tick(32'hC0, 0, "R5 run2 edge1");
    tick(32'hC0, 0, "R5 run2 edge2");
    tick(32'hC0, 0, "R5 run2 edge3");
    smp[7] = 12'd150;
    tick(32'h40, 0, "R5 break edge4");
    tick(32'h40, 0, "R5 break edge5");
    smp[7] = 12'd201;
    tick(32'hC0, 0, "R5 restart edge6");
    tick(32'hC0, 0, "R5 restart edge7");
    tick(32'hC0, 0, "R5 restart edge8");
    tick(32'hC0, 0, "R5 restart edge9");
    rd_addr = 1'b1;
    tick(32'hC0, 1, "R5 restart edge10 trip");
    rst = 1'b1;
    tick('0, 0, "R8 reset with faults");
    rst = 1'b0;
    tick(32'hC0, 0, "R8 counter restarted");
    tick(32'hC0, 0, "R8 counter restarted");
    all_ok();
    tick('0, 0, "R8 end");
    @(posedge clk);
    #6;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule